// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This unit keeps one interrupt-enable register and one interrupt-status register for each of a fixed number of localities. It also holds a read-only vector register. Event pulses arrive from the rest of the security-module front end. Each pulse carries a locality index and a four-bit event set: data available, status valid, locality changed and command ready. The unit latches every event that the target locality has enabled. It drives one shared interrupt pin whose active level comes from the polarity field of the locality that raised it.

Software reaches the registers through a small select-and-strobe register port with byte enables. Reads return on the same cycle as the read strobe, and any locality may read its own registers. Writes to enable or status are accepted only from the locality that currently owns the interface. The line is released when a write-one-to-clear leaves that locality's status at zero.

Top module: `irqc_unit`

## Requirements
- R1: Register select codes are 0 for enable, 1 for status and 2 for vector. Enable bit 31 is the global enable and bits 4:3 are the polarity code. Event bits sit at bit 0 (data available), bit 1 (status valid), bit 2 (locality changed) and bit 7 (command ready), in both the enable and the status register. The event input maps evt_bits[0], [1], [2] and [3] to bits 0, 1, 2 and 7 in that order. Status bits other than 0, 1, 2 and 7 always read zero.
- R2: After reset every enable register reads 0x00000008 (polarity code 01, all enables clear), every status register reads 0, and irq_pin is high.
- R3: An event sets a status bit of its locality only when that locality has both the global enable and the enable for that event set. An accepted event asserts the line.
- R4: An enable write changes only the bytes whose reg_be bit is set. Within those bytes only bits 31, 7, 4, 3, 2, 1 and 0 take the written value, and every other bit stays zero.
- R5: Status bits are cleared by writing one to them. The line is released only when such a write leaves that locality's status at zero; a clear that leaves any bit set keeps the line asserted.
- R6: Enable and status writes are ignored unless act_vld is high and reg_loc equals act_loc.
- R7: Events whose locality index is not below the locality count are ignored.
- R8: A vector read returns the parameter VECTOR_NUM (0 to 15), and writes to the vector register have no effect.
- R9: Polarity code 01 of the raising locality makes irq_pin active low. Any other code makes it active high. When the line is not asserted, irq_pin sits at the inactive level of that code.
- R10: reg_rdata carries the selected register in the same cycle as reg_rd for any locality, whether it is active or not, and reads 0 when reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_vld | input | 1 | A locality currently owns the interface |
| act_loc | input | LOC_W | Index of the owning locality |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_loc | input | LOC_W | Locality of the register access |
| reg_sel | input | 2 | Register select (0 enable, 1 status, 2 vector) |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_rd |
| evt_vld | input | 1 | Event pulse valid |
| evt_loc | input | LOC_W | Locality the event belongs to |
| evt_bits | input | 4 | Event set: data avail, status valid, locality changed, command ready |
| irq_pin | output | 1 | Shared interrupt pin at its physical level |

## Verification
Every cycle, the bound checker watches several behaviours. Reserved enable and status bits must stay zero. A foreign locality's enable write must leave the enable unchanged. An event seen while the global enable is off must leave status untouched. Out-of-range event indices must change nothing, and vector reads must return the constant. Other behaviours show only in the bench's ordered scenarios: byte-lane merging of enable writes, the line staying up through a partial clear and dropping on the final one, and the pin level flipping with each locality's polarity code.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned DW = 32;

  // status bits that events may set
  localparam logic [DW-1:0] EVT_FIELD  = 32'h0000_0087;
  // enable bits that software may write
  localparam logic [DW-1:0] EN_WMASK   = 32'h8000_009F;
  // enable reset value: polarity code 01, nothing enabled
  localparam logic [DW-1:0] EN_RESET   = 32'h0000_0008;
  localparam int unsigned   GLB_BIT    = 31;
  localparam int unsigned   POL_LSB    = 3;
  localparam logic [1:0]    POL_ACT_LO = 2'b01;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_STS  = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [DW-1:0] evt_to_field(input logic [3:0] e);
    return {24'b0, e[3], 4'b0000, e[2:0]};
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [3:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/irqc_loc_regs.sv
module irqc_loc_regs
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sts,
  input  logic [DW-1:0] bmask,
  input  logic [DW-1:0] wdata,
  input  logic          evt_hit,
  input  logic [DW-1:0] evt_vec,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] sts_q,
  output logic          set_any,
  output logic          drop
);

  logic [DW-1:0] en_d, sts_d, set_v, clr_v;
  logic          en_upd, sts_upd;

  always_comb begin
    set_v   = evt_hit ? (evt_vec & en_q & {DW{en_q[GLB_BIT]}}) : '0;
    clr_v   = wr_sts ? (wdata & bmask & EVT_FIELD) : '0;
    sts_d   = (sts_q & ~clr_v) | set_v;
    sts_upd = evt_hit | wr_sts;
    en_d    = (en_q & ~bmask) | (wdata & bmask & EN_WMASK);
    en_upd  = wr_en;
    set_any = |set_v;
    drop    = (|clr_v) && (|sts_q) && (sts_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_RESET;
      sts_q <= '0;
    end else begin
      if (en_upd)  en_q  <= en_d;
      if (sts_upd) sts_q <= sts_d;
    end
  end

endmodule

// File: rtl/irqc_line.sv
module irqc_line #(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 raise,
  input  logic [LOC_W-1:0]     raise_loc,
  input  logic                 drop,
  input  logic [2*NUM_LOC-1:0] pol_flat,
  output logic                 line_on,
  output logic                 irq_pin
);

  import irqc_pkg::*;

  logic             line_d, upd;
  logic [LOC_W-1:0] src_q, src_d;
  logic [1:0]       pol;

  always_comb begin
    upd    = raise | drop;
    line_d = raise ? 1'b1 : 1'b0;
    src_d  = raise ? raise_loc : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_on <= 1'b0;
      src_q   <= '0;
    end else if (upd) begin
      line_on <= line_d;
      src_q   <= src_d;
    end
  end

  always_comb begin
    pol     = pol_flat[int'(src_q)*2 +: 2];
    irq_pin = (pol == POL_ACT_LO) ? ~line_on : line_on;
  end

endmodule

// File: rtl/irqc_unit.sv
module irqc_unit #(
  parameter int unsigned NUM_LOC    = 5,
  parameter int unsigned LOC_W      = 3,
  parameter int unsigned VECTOR_NUM = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_vld,
  input  logic [LOC_W-1:0] act_loc,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [LOC_W-1:0] reg_loc,
  input  logic [1:0]       reg_sel,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             evt_vld,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [3:0]       evt_bits,
  output logic             irq_pin
);

  import irqc_pkg::*;

  localparam logic [DW-1:0] VEC_WORD = DW'(VECTOR_NUM);

  logic [NUM_LOC*DW-1:0] en_flat, sts_flat;
  logic [2*NUM_LOC-1:0]  pol_flat;
  logic [NUM_LOC-1:0]    set_v, drop_v;
  logic [DW-1:0]         bmask, evt_vec;
  logic                  owner_wr, line_on;
  reg_sel_e              sel;

  always_comb begin
    sel      = reg_sel_e'(reg_sel);
    bmask    = lane_mask(reg_be);
    evt_vec  = evt_to_field(evt_bits);
    owner_wr = reg_wr && act_vld && (act_loc == reg_loc);
  end

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    logic          wr_en_g, wr_sts_g, hit_g;
    logic [DW-1:0] en_g, sts_g;

    assign wr_en_g  = owner_wr && (reg_loc == LOC_W'(g)) && (sel == SEL_EN);
    assign wr_sts_g = owner_wr && (reg_loc == LOC_W'(g)) && (sel == SEL_STS);
    assign hit_g    = evt_vld && (evt_loc == LOC_W'(g));

    irqc_loc_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_g),
      .wr_sts  (wr_sts_g),
      .bmask   (bmask),
      .wdata   (reg_wdata),
      .evt_hit (hit_g),
      .evt_vec (evt_vec),
      .en_q    (en_g),
      .sts_q   (sts_g),
      .set_any (set_v[g]),
      .drop    (drop_v[g])
    );

    assign en_flat[g*DW +: DW]  = en_g;
    assign sts_flat[g*DW +: DW] = sts_g;
    assign pol_flat[g*2 +: 2]   = en_g[POL_LSB +: 2];
  end

  irqc_line #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (|set_v),
    .raise_loc (evt_loc),
    .drop      (|drop_v),
    .pol_flat  (pol_flat),
    .line_on   (line_on),
    .irq_pin   (irq_pin)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel == SEL_VEC) begin
        reg_rdata = VEC_WORD;
      end else if (int'(reg_loc) < NUM_LOC) begin
        if (sel == SEL_EN)  reg_rdata = en_flat[int'(reg_loc)*DW +: DW];
        if (sel == SEL_STS) reg_rdata = sts_flat[int'(reg_loc)*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/irqc_unit_chk.sv
module irqc_unit_chk #(
  parameter int unsigned NUM_LOC    = 5,
  parameter int unsigned LOC_W      = 3,
  parameter int unsigned VECTOR_NUM = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 act_vld,
  input logic [LOC_W-1:0]     act_loc,
  input logic                 reg_rd,
  input logic                 reg_wr,
  input logic [LOC_W-1:0]     reg_loc,
  input logic [1:0]           reg_sel,
  input logic [31:0]          reg_rdata,
  input logic                 evt_vld,
  input logic [LOC_W-1:0]     evt_loc,
  input logic [NUM_LOC*32-1:0] en_flat,
  input logic [NUM_LOC*32-1:0] sts_flat
);

  import irqc_pkg::*;

  AST_VEC_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_VEC) |-> (reg_rdata == 32'(VECTOR_NUM))); // R8

  AST_BAD_LOC_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && int'(evt_loc) >= NUM_LOC && !reg_wr) |=> $stable(sts_flat)); // R7

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_chk
    AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en_flat[g*32 +: 32] & ~EN_WMASK) == '0); // R4

    AST_STS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_flat[g*32 +: 32] & ~EVT_FIELD) == '0); // R1

    AST_FOREIGN_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == SEL_EN && reg_loc == LOC_W'(g) &&
       !(act_vld && act_loc == LOC_W'(g))) |=> $stable(en_flat[g*32 +: 32])); // R6

    AST_GLOBAL_OFF_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vld && evt_loc == LOC_W'(g) && !en_flat[g*32 + 31] &&
       !(reg_wr && reg_sel == SEL_STS && reg_loc == LOC_W'(g)))
      |=> $stable(sts_flat[g*32 +: 32])); // R3
  end

endmodule

bind irqc_unit irqc_unit_chk #(
  .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VECTOR_NUM(VECTOR_NUM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .act_vld   (act_vld),
  .act_loc   (act_loc),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_loc   (reg_loc),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .evt_vld   (evt_vld),
  .evt_loc   (evt_loc),
  .en_flat   (en_flat),
  .sts_flat  (sts_flat)
);

// File: tb/irqc_unit_test.sv
module irqc_unit_test;

  localparam int CLK_PER = 10;
  localparam int LW      = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          act_vld = 1'b0;
  logic [LW-1:0] act_loc = '0;
  logic          reg_rd = 1'b0, reg_wr = 1'b0;
  logic [LW-1:0] reg_loc = '0;
  logic [1:0]    reg_sel = '0;
  logic [3:0]    reg_be = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          evt_vld = 1'b0;
  logic [LW-1:0] evt_loc = '0;
  logic [3:0]    evt_bits = '0;
  logic          irq_pin;
  logic          chk_pin = 1'b0;

  int total = 0;
  int bad = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  irqc_unit #(.NUM_LOC(5), .LOC_W(LW), .VECTOR_NUM(11)) uut (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_loc(act_loc),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_loc(reg_loc), .reg_sel(reg_sel),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_vld(evt_vld), .evt_loc(evt_loc), .evt_bits(evt_bits),
    .irq_pin(irq_pin)
  );

  // monitor: pops expectations when a read or pin probe is live
  always @(negedge clk) begin
    if (reg_rd || chk_pin) begin
      logic [31:0] act, exp;
      string       tg;
      act = reg_rd ? reg_rdata : {31'b0, irq_pin};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", act);
      end else begin
        exp = exp_q.pop_front();
        tg  = tag_q.pop_front();
        if (act !== exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
      end
    end
  end

  task automatic wr(input logic [LW-1:0] l, input logic [1:0] s,
                    input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_loc = l; reg_sel = s; reg_be = be; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic evt(input logic [LW-1:0] l, input logic [3:0] b);
    @(posedge clk); #1;
    evt_vld = 1'b1; evt_loc = l; evt_bits = b;
    @(posedge clk); #1;
    evt_vld = 1'b0;
  endtask

  task automatic rd(input logic [LW-1:0] l, input logic [1:0] s,
                    input logic [31:0] exp, input string tg);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tg);
    reg_rd = 1'b1; reg_loc = l; reg_sel = s;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic pin(input logic exp, input string tg);
    @(posedge clk); #1;
    exp_q.push_back({31'b0, exp}); tag_q.push_back(tg);
    chk_pin = 1'b1;
    @(posedge clk); #1;
    chk_pin = 1'b0;
  endtask

  localparam logic [1:0] EN = 2'd0, ST = 2'd1, VC = 2'd2;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(0, EN, 32'h0000_0008, "R2 enable reset");
    rd(4, ST, 32'h0, "R2 status reset");
    pin(1'b1, "R2 pin idle");

    rd(2, VC, 32'd11, "R8 vector read");
    act_vld = 1'b1; act_loc = 2;
    wr(2, VC, 4'hF, 32'hFFFF_FFFF);
    rd(2, VC, 32'd11, "R8 vector after write");

    act_vld = 1'b0;
    wr(1, EN, 4'hF, 32'hFFFF_FFFF);
    rd(1, EN, 32'h0000_0008, "R6 write with no owner");

    act_vld = 1'b1; act_loc = 1;
    wr(1, EN, 4'h1, 32'h0000_00FF);
    rd(1, EN, 32'h0000_009F, "R4 low lane write");
    wr(1, EN, 4'h8, 32'hFFFF_FFFF);
    rd(1, EN, 32'h8000_009F, "R4 top lane write");
    wr(1, EN, 4'h4, 32'hFFFF_FFFF);
    rd(1, EN, 32'h8000_009F, "R4 reserved lane");
    wr(1, EN, 4'h1, 32'h0000_008B);
    rd(1, EN, 32'h8000_008B, "R4 polarity 01 set");

    wr(0, EN, 4'hF, 32'hFFFF_FFFF);
    rd(0, EN, 32'h0000_0008, "R6 non-owner enable");

    evt(1, 4'b0100);
    rd(1, ST, 32'h0, "R3 disabled event");
    pin(1'b1, "R3 pin stays idle");

    evt(1, 4'b1001);
    rd(1, ST, 32'h0000_0081, "R1 R3 event mapping");
    pin(1'b0, "R9 active-low asserted");

    evt(7, 4'hF);
    evt(5, 4'hF);
    rd(1, ST, 32'h0000_0081, "R7 bad locality ignored");

    wr(0, ST, 4'hF, 32'hFFFF_FFFF);
    rd(1, ST, 32'h0000_0081, "R6 non-owner clear");

    wr(1, ST, 4'hF, 32'h0000_0001);
    rd(1, ST, 32'h0000_0080, "R5 partial clear");
    pin(1'b0, "R5 line kept");

    wr(1, ST, 4'h1, 32'h0000_0080);
    rd(1, ST, 32'h0, "R5 full clear");
    pin(1'b1, "R5 line released");

    wr(1, EN, 4'h8, 32'h0);
    evt(1, 4'b0001);
    rd(1, ST, 32'h0, "R3 global off");
    pin(1'b1, "R3 pin idle global off");

    wr(1, EN, 4'hF, 32'h8000_0001);
    evt(1, 4'b0001);
    pin(1'b1, "R9 active-high asserted");
    wr(1, ST, 4'hF, 32'h0000_0001);
    pin(1'b0, "R9 active-high idle");

    act_loc = 3;
    rd(1, EN, 32'h8000_0001, "R10 read of non-owner");
    rd(1, ST, 32'h0, "R10 status non-owner");

    @(posedge clk); #1;
    summary();
  end

endmodule